// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin GPIO Bank

This block is one bank of general-purpose I/O pins behind a small memory-mapped register bus. Each pin can be an input or an output. When it is an output, the pin drives the value held in a data register. Each pin can also raise an interrupt. The trigger is chosen per pin from low level, high level, rising edge and falling edge. A separate per-pin control makes the pin trigger on every transition instead.

Pad inputs pass through a two-flop synchronizer before they reach trigger detection. Each pin has a sticky status bit that latches when the pin triggers. Software clears a status bit by writing one to it. A mask register decides which status bits reach the single combined interrupt line. Software is expected to scan status from pin 0 upward and service the lowest pending pin first.

The bus has one request strobe plus a write flag, a byte address and 32-bit data. Writes take effect at the clock edge where the request is seen. Read data is registered and is valid one cycle after the request.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the data, direction, mask, both-edges and both trigger-configuration registers read zero. The pad output enables and the combined interrupt are low.
- R2: The data register value is always presented on the pad output vector. A direction bit of 1 sets that pin's output enable, and a 0 clears it so the pin is an input.
- R3: A value written to the data register while a pin is an input appears on the pad output. When the direction bit is later set, the pad drives that value starting the cycle after the direction write.
- R4: Register offsets are 0x00 data, 0x04 direction, 0x08 synchronized pad state (read-only), 0x0C trigger configuration for pins 0–15, 0x10 trigger configuration for pins 16–31, 0x14 mask, 0x18 status, 0x1C both-edges. Read data is valid one cycle after the read request.
- R5: The 2-bit trigger code of pin p sits at bits 2*(p mod 16)+1 : 2*(p mod 16) of the configuration register for its half. The codes are 00 low level, 01 high level, 10 rising edge, 11 falling edge.
- R6: A level-triggered pin sets its status bit on every cycle its synchronized level matches the code. Reset leaves every code at 00 and every synchronizer at 0, so all status bits set right after reset.
- R7: An edge trigger compares the synchronized pad value with its value one cycle earlier. A pad change is reflected in status, and in the combined interrupt, at the third rising clock edge after the change. A transition in the other direction does not set status.
- R8: When a pin's both-edges bit is 1, the pin sets status on both rising and falling transitions, and its 2-bit code is ignored.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a trigger fall in the same cycle, the bit stays set.
- R10: The combined interrupt is high when any pin has both its status bit and its mask bit set. A masked pin still latches status.
- R11: Writes to the pad-state offset, to offsets at 0x20 and above, or to addresses that are not word aligned change no register. Reads at offsets 0x20 and above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Register access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| padIn | input | 32 | Asynchronous pad input levels |
| padOut | output | 32 | Pad output values |
| padOe | output | 32 | Pad output enables |
| irqOut | output | 1 | Combined interrupt |

## Verification
The block has three latencies. A register write is visible at the outputs one clock edge after the request. Read data arrives one edge after a read request. A pad change reaches status and the interrupt at the third edge, because it passes two synchronizer flops and then the status flop. The combined interrupt follows status and mask with no added register. The bench drives every stimulus on a falling edge and counts the rising edges up to each due cycle. For pad events it checks that the interrupt is still low after two edges and high after the third, so the latency is fixed exactly rather than only bounded.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trigCode_e;

  // word index = byte offset / 4
  typedef enum logic [2:0] {
    SEL_DATA   = 3'd0,
    SEL_DIR    = 3'd1,
    SEL_PAD    = 3'd2,
    SEL_CFGLO  = 3'd3,
    SEL_CFGHI  = 3'd4,
    SEL_MASK   = 3'd5,
    SEL_STATUS = 3'd6,
    SEL_BOTH   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrCfgLo;
    logic    wrCfgHi;
    logic    wrMask;
    logic    wrStatus;
    logic    wrBoth;
    logic    rdEn;
    logic    rdHit;
    regSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);

  localparam int unsigned MAP_BITS = 5;

  logic    inMap;
  logic    aligned;
  logic    wrOk;
  regSel_e sel;

  assign inMap   = (busAddr >> MAP_BITS) == '0;
  assign aligned = busAddr[1:0] == 2'b00;
  assign sel     = regSel_e'(busAddr[4:2]);
  assign wrOk    = busValid && busWrite && inMap && aligned;

  always_comb begin
    strobe          = '0;
    strobe.wrData   = wrOk && (sel == SEL_DATA);
    strobe.wrDir    = wrOk && (sel == SEL_DIR);
    strobe.wrCfgLo  = wrOk && (sel == SEL_CFGLO);
    strobe.wrCfgHi  = wrOk && (sel == SEL_CFGHI);
    strobe.wrMask   = wrOk && (sel == SEL_MASK);
    strobe.wrStatus = wrOk && (sel == SEL_STATUS);
    strobe.wrBoth   = wrOk && (sel == SEL_BOTH);
    strobe.rdEn     = busValid && !busWrite;
    strobe.rdHit    = inMap;
    strobe.rdSel    = sel;
  end

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_CNT = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic [PIN_CNT-1:0] wdata,
  input  logic [PIN_CNT-1:0] padIn,
  output logic [PIN_CNT-1:0] padOut,
  output logic [PIN_CNT-1:0] padOe,
  output logic [PIN_CNT-1:0] rdata,
  output logic [PIN_CNT-1:0] statusVec,
  output logic [PIN_CNT-1:0] maskVec
);

  localparam int unsigned HALF  = PIN_CNT / 2;
  localparam int unsigned CFG_W = 2 * HALF;

  logic [PIN_CNT-1:0] dataQ, dirQ, maskQ, statusQ, bothQ;
  logic [CFG_W-1:0]   cfgLoQ, cfgHiQ;
  logic [PIN_CNT-1:0] syncA, syncB, prevB;
  logic [PIN_CNT-1:0] trig;
  logic [PIN_CNT-1:0] clrVec;
  logic [PIN_CNT-1:0] rdMux;
  logic [PIN_CNT-1:0] rdataQ;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      dirQ   <= '0;
      maskQ  <= '0;
      bothQ  <= '0;
      cfgLoQ <= '0;
      cfgHiQ <= '0;
    end else begin
      if (strobe.wrData)  dataQ  <= wdata;
      if (strobe.wrDir)   dirQ   <= wdata;
      if (strobe.wrMask)  maskQ  <= wdata;
      if (strobe.wrBoth)  bothQ  <= wdata;
      if (strobe.wrCfgLo) cfgLoQ <= wdata[CFG_W-1:0];
      if (strobe.wrCfgHi) cfgHiQ <= wdata[CFG_W-1:0];
    end
  end

  // two-flop synchronizer plus one history stage for edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  // per-pin trigger detection
  for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
    localparam int unsigned FIELD_LSB = 2 * (p % HALF);
    logic [1:0] code;
    logic       rise, fall, hit;

    if (p < HALF) begin : g_lo
      assign code = cfgLoQ[FIELD_LSB +: 2];
    end else begin : g_hi
      assign code = cfgHiQ[FIELD_LSB +: 2];
    end

    assign rise = syncB[p] & ~prevB[p];
    assign fall = ~syncB[p] & prevB[p];

    always_comb begin
      if (bothQ[p]) begin
        hit = rise | fall;
      end else begin
        unique case (trigCode_e'(code))
          TRIG_LOW:  hit = ~syncB[p];
          TRIG_HIGH: hit = syncB[p];
          TRIG_RISE: hit = rise;
          TRIG_FALL: hit = fall;
          default:   hit = 1'b0;
        endcase
      end
    end

    assign trig[p] = hit;
  end

  // sticky status, write-one-to-clear, set wins
  assign clrVec = strobe.wrStatus ? wdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrVec) | trig;
  end

  // read path
  always_comb begin
    rdMux = '0;
    if (strobe.rdHit) begin
      unique case (strobe.rdSel)
        SEL_DATA:   rdMux = dataQ;
        SEL_DIR:    rdMux = dirQ;
        SEL_PAD:    rdMux = syncB;
        SEL_CFGLO:  rdMux[CFG_W-1:0] = cfgLoQ;
        SEL_CFGHI:  rdMux[CFG_W-1:0] = cfgHiQ;
        SEL_MASK:   rdMux = maskQ;
        SEL_STATUS: rdMux = statusQ;
        SEL_BOTH:   rdMux = bothQ;
        default:    rdMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdataQ <= '0;
    else if (strobe.rdEn) rdataQ <= rdMux;
  end

  assign padOut    = dataQ;
  assign padOe     = dirQ;
  assign rdata     = rdataQ;
  assign statusVec = statusQ;
  assign maskVec   = maskQ;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_CNT = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [PIN_CNT-1:0] busWdata,
  output logic [PIN_CNT-1:0] busRdata,
  input  logic [PIN_CNT-1:0] padIn,
  output logic [PIN_CNT-1:0] padOut,
  output logic [PIN_CNT-1:0] padOe,
  output logic               irqOut
);

  regStrobe_t         strobe;
  logic [PIN_CNT-1:0] statusVec;
  logic [PIN_CNT-1:0] maskVec;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  gpio_bank_datapath #(.PIN_CNT(PIN_CNT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wdata     (busWdata),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .rdata     (busRdata),
    .statusVec (statusVec),
    .maskVec   (maskVec)
  );

  assign irqOut = |(statusVec & maskVec);

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int unsigned PIN_CNT = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               busValid,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [PIN_CNT-1:0] busWdata,
  input logic [PIN_CNT-1:0] busRdata,
  input logic [PIN_CNT-1:0] padOut,
  input logic [PIN_CNT-1:0] padOe,
  input logic               irqOut,
  input logic [PIN_CNT-1:0] statusVec,
  input logic [PIN_CNT-1:0] maskVec
);

  localparam logic [ADDR_W-1:0] OFS_DATA   = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_DIR    = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFS_END    = ADDR_W'(8'h20);

  logic wrStat;
  assign wrStat = busValid && busWrite && (busAddr == OFS_STATUS);

  assert_data_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == OFS_DATA) |=> (padOut == $past(busWdata)));

  assert_dir_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == OFS_DIR) |=> (padOe == $past(busWdata)));

  assert_sticky_status_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wrStat |=> (($past(statusVec) & ~statusVec) == '0));

  assert_w1c_zero_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrStat |=> (($past(statusVec) & ~$past(busWdata) & ~statusVec) == '0));

  assert_mask_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |-> !irqOut);

  assert_unmapped_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr >= OFS_END) |=> (busRdata == '0));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.PIN_CNT(PIN_CNT), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .padOut    (padOut),
  .padOe     (padOe),
  .irqOut    (irqOut),
  .statusVec (statusVec),
  .maskVec   (maskVec)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] padIn = '0;
  logic [31:0] padOut;
  logic [31:0] padOe;
  logic        irqOut;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_bank u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .irqOut   (irqOut)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busValid = 1'b0;
  endtask

  task automatic setPad(input logic [31:0] v);
    @(negedge clk);
    padIn = v;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearAll();
    logic [31:0] v;
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, v);
    check("R9 clear all status", v, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 padOe after reset", padOe, 32'h0);
    check("R1 padOut after reset", padOut, 32'h0);
    check("R1 irq after reset", {31'h0, irqOut}, 32'h0);
    rd(6'h00, v); check("R1 data reset", v, 32'h0);
    rd(6'h04, v); check("R1 dir reset", v, 32'h0);
    rd(6'h0C, v); check("R1 cfg lo reset", v, 32'h0);
    rd(6'h10, v); check("R1 cfg hi reset", v, 32'h0);
    rd(6'h14, v); check("R1 mask reset", v, 32'h0);
    rd(6'h1C, v); check("R1 both reset", v, 32'h0);
    rd(6'h18, v); check("R6 low-level default sets all status", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_padRead();
    logic [31:0] v;
    wr(6'h0C, 32'hAAAA_AAAA);
    wr(6'h10, 32'hAAAA_AAAA);
    clearAll();
    setPad(32'h1234_5678);
    waitEdges(3);
    rd(6'h08, v); check("R4 pad state read", v, 32'h1234_5678);
    rd(6'h18, v); check("R7 rising pins latched", v, 32'h1234_5678);
    setPad(32'h0);
    waitEdges(3);
    rd(6'h18, v); check("R7 falling ignored under rising code", v, 32'h1234_5678);
    clearAll();
  endtask

  task automatic t_direction();
    logic [31:0] v;
    wr(6'h00, 32'h0000_A5A5);
    check("R2 data on padOut while input", padOut, 32'h0000_A5A5);
    check("R2 no enables while input", padOe, 32'h0);
    wr(6'h04, 32'h0000_FF00);
    check("R3 preload then enable", padOe, 32'h0000_FF00);
    check("R3 preloaded value driven", padOut, 32'h0000_A5A5);
    rd(6'h04, v); check("R4 dir readback", v, 32'h0000_FF00);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(6'h20, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    wr(6'h05, 32'hFFFF_FFFF);
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h00, v); check("R11 data untouched", v, 32'h0000_A5A5);
    rd(6'h04, v); check("R11 dir untouched", v, 32'h0000_FF00);
    check("R11 padOe untouched", padOe, 32'h0000_FF00);
    rd(6'h08, v); check("R11 pad state not writable", v, 32'h0);
    rd(6'h20, v); check("R11 unmapped read zero", v, 32'h0);
    rd(6'h14, v); check("R11 mask untouched", v, 32'h0);
  endtask

  task automatic t_riseLatency();
    logic [31:0] v;
    wr(6'h14, 32'h0000_0008);
    setPad(32'h0000_0008);
    waitEdges(2);
    check("R7 irq not yet after two edges", {31'h0, irqOut}, 32'h0);
    waitEdges(1);
    check("R7 irq on third edge", {31'h0, irqOut}, 32'h1);
    wr(6'h18, 32'h0000_0008);
    check("R9 clear drops irq", {31'h0, irqOut}, 32'h0);
    setPad(32'h0);
    waitEdges(4);
    rd(6'h18, v); check("R7 falling does not set rising pin", v, 32'h0);
  endtask

  task automatic t_falling();
    logic [31:0] v;
    wr(6'h10, 32'hAAAA_ABAA);
    setPad(32'h0010_0000);
    waitEdges(4);
    rd(6'h18, v); check("R5 falling code ignores rise on pin 20", v, 32'h0);
    setPad(32'h0);
    waitEdges(3);
    rd(6'h18, v); check("R5 falling code sets pin 20", v, 32'h0010_0000);
    clearAll();
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(6'h0C, 32'hAAAA_A6AA);
    setPad(32'h0000_0020);
    waitEdges(3);
    rd(6'h18, v); check("R6 high level sets pin 5", v, 32'h0000_0020);
    wr(6'h18, 32'h0000_0020);
    rd(6'h18, v); check("R9 set wins over clear while level active", v, 32'h0000_0020);
    wr(6'h18, 32'h0000_0000);
    rd(6'h18, v); check("R9 writing zero keeps status", v, 32'h0000_0020);
    setPad(32'h0);
    waitEdges(3);
    clearAll();
  endtask

  task automatic t_both();
    logic [31:0] v;
    wr(6'h1C, 32'h0000_0200);
    setPad(32'h0000_0200);
    waitEdges(3);
    rd(6'h18, v); check("R8 both-edges rise on pin 9", v, 32'h0000_0200);
    wr(6'h18, 32'h0000_0200);
    setPad(32'h0);
    waitEdges(3);
    rd(6'h18, v); check("R8 both-edges fall on pin 9", v, 32'h0000_0200);
    clearAll();
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(6'h14, 32'h0);
    setPad(32'h0000_0008);
    waitEdges(3);
    check("R10 masked pin no irq", {31'h0, irqOut}, 32'h0);
    rd(6'h18, v); check("R10 masked pin still latches", v, 32'h0000_0008);
    wr(6'h14, 32'h0000_0008);
    check("R10 unmask raises irq", {31'h0, irqOut}, 32'h1);
    wr(6'h14, 32'h0000_0004);
    check("R10 other mask bit no irq", {31'h0, irqOut}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_padRead();
    t_direction();
    t_ignored();
    t_riseLatency();
    t_falling();
    t_level();
    t_both();
    t_mask();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule